// File: doc/BRIEF.md
# Block Hamming Check Engine for NAND Page Data

This engine sits next to a NAND data path. It watches the byte stream of a page and builds a 24-bit single-error-correcting, double-error-detecting parity code for every 512-byte block. On a program operation, software reads the per-block codes and writes them into the spare area behind the page data. On a read operation, software streams the page through the engine again. It then presents each stored code read back from the spare area. The engine forms the syndrome and records a per-block verdict, and for a single flipped data bit it also records the byte and bit position. The engine reports the position only and leaves the buffer untouched.

Calculation is armed only by an access whose address is 512-byte aligned. The page ends with an explicit last flag on its final byte, and that byte must fall exactly on a block boundary. A last flag that comes early closes the page, sets a sticky misalignment flag and marks the open block invalid. Up to four blocks (a 2 KiB page) are held by default.

Top module: `nand_block_ecc`

## Requirements
- R1: After reset, done and misalign are 0, and every block slot reads code 0, status clean (0) and invalid 0.
- R2: A start access whose low nine address bits are not all zero does not arm the engine. Bytes that follow it are ignored: done stays 0 and the stored codes are unchanged.
- R3: Code layout: the code holds 12 parity pairs. Bit 2p is the even half and bit 2p+1 the odd half of pair p. Pairs 0..2 cover data bits whose bit number has bit p clear (even half) or set (odd half). Pairs 3..11 do the same for bit p-3 of the byte's index within the block.
- R4: Consecutive 512-byte blocks after an aligned start go to slots 0,1,2,3 in order, and each slot is readable through rd_idx_i.
- R5: A byte taken with the last flag at block offset 511 closes the page. done rises at that clock edge, and bytes after it are ignored. Completing the final slot also closes the page.
- R6: Comparing a stored code equal to the computed one gives status 0 (clean).
- R7: A syndrome in which every pair has exactly one bit set gives status 1 (corrected). The byte index is the odd bits of pairs 3..11 and the bit index is the odd bits of pairs 0..2.
- R8: A syndrome with exactly one bit set gives status 2 (error in the stored code).
- R9: Any other nonzero syndrome, such as two flipped data bits, gives status 3 (uncorrectable).
- R10: A last flag on a byte other than block offset 511 sets a sticky misalign flag and sets the invalid bit of the open slot. It also raises done.
- R11: done is cleared by sw_clr_i or by the next aligned start. misalign is cleared only by sw_clr_i. An aligned start clears every slot's status and invalid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_start_i | input | 1 | Start of a NAND data access |
| acc_addr_lo_i | input | 9 | Low address bits of that access |
| data_valid_i | input | 1 | Data byte present |
| data_i | input | 8 | Data byte |
| data_last_i | input | 1 | Final byte of the page |
| cmp_valid_i | input | 1 | Stored code present for comparison |
| cmp_idx_i | input | 2 | Slot the stored code belongs to |
| cmp_code_i | input | 24 | Code read back from the spare area |
| sw_clr_i | input | 1 | Software clear of done and misalign |
| rd_idx_i | input | 2 | Slot selected for readout |
| rd_code_o | output | 24 | Computed code of the selected slot |
| rd_status_o | output | 2 | Verdict: 0 clean, 1 corrected, 2 code error, 3 uncorrectable |
| rd_invalid_o | output | 1 | Selected block ended early |
| rd_byte_o | output | 9 | Byte index of a corrected error |
| rd_bit_o | output | 3 | Bit index of a corrected error |
| done_o | output | 1 | Page codes final |
| misalign_o | output | 1 | Sticky early-last flag |

## Verification
The bench computes each code with its own bit-serial model. It uses all-zero, all-one, index-derived and pseudo-random blocks, so that line pairs and column pairs are each exercised with parities of both polarities. For comparison it supplies a matching code, single data-bit flips at offset 0, offset 511 and a middle offset, single flipped code bits, and double data flips. These cases separate the four verdicts and check that the reported location follows the flipped position. Directed cases cover an unaligned start, a four-block page, an early last flag and both ways of clearing done.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int BLK_BYTES = 512;
    localparam int BYTE_W    = $clog2(BLK_BYTES);
    localparam int BIT_W     = 3;
    localparam int PAIRS     = BYTE_W + BIT_W;
    localparam int CODE_W    = 2 * PAIRS;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        ST_CLEAN   = 2'd0,
        ST_FIXED   = 2'd1,
        ST_CODEERR = 2'd2,
        ST_BAD     = 2'd3
    } blk_stat_e;

    typedef struct packed {
        blk_stat_e          stat;
        logic               invalid;
        logic [BYTE_W-1:0]  byte_loc;
        logic [BIT_W-1:0]   bit_loc;
    } blk_rep_t;

    // Parity contribution of one byte at a given offset inside its block.
    function automatic code_t byte_contrib(input logic [BYTE_W-1:0] idx,
                                           input logic [7:0] d);
        code_t      c;
        logic       xp;
        logic [7:0] m;
        c  = '0;
        xp = ^d;
        for (int k = 0; k < BIT_W; k++) begin
            for (int b = 0; b < 8; b++) begin
                m[b] = ((b >> k) & 1) == 1;
            end
            c[2*k+1] = ^(d & m);
            c[2*k]   = ^(d & ~m);
        end
        for (int j = 0; j < BYTE_W; j++) begin
            if (idx[j]) c[2*(BIT_W+j)+1] = xp;
            else        c[2*(BIT_W+j)]   = xp;
        end
        return c;
    endfunction

endpackage

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
    import nand_ecc_pkg::*;
#(
    parameter int NUM_BLK = 4,
    parameter int IDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic              valid_i,
    input  logic              last_i,
    input  logic              sw_clr_i,
    output logic              take_o,
    output logic [BYTE_W-1:0] idx_o,
    output logic [IDX_W-1:0]  blk_o,
    output logic              blk_end_o,
    output logic              early_o,
    output logic              done_o,
    output logic              mis_o
);

    localparam logic [BYTE_W-1:0] LAST_OFF = BYTE_W'(BLK_BYTES - 1);
    localparam logic [IDX_W-1:0]  LAST_BLK = IDX_W'(NUM_BLK - 1);

    logic              active_q;
    logic [BYTE_W-1:0] cnt_q;
    logic [IDX_W-1:0]  blk_q;
    logic              done_q, mis_q;
    logic              take, blk_end, early, close_pg;

    assign take     = active_q && valid_i && !arm_i;
    assign blk_end  = take && (cnt_q == LAST_OFF);
    assign early    = take && last_i && !blk_end;
    assign close_pg = (take && last_i) || (blk_end && (blk_q == LAST_BLK));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            blk_q    <= '0;
            done_q   <= 1'b0;
            mis_q    <= 1'b0;
        end else begin
            if (sw_clr_i) begin
                done_q <= 1'b0;
                mis_q  <= 1'b0;
            end
            if (arm_i) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
                blk_q    <= '0;
                done_q   <= 1'b0;
            end else if (take) begin
                cnt_q <= cnt_q + 1'b1;
                if (blk_end) blk_q <= blk_q + 1'b1;
                if (close_pg) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
                if (early) mis_q <= 1'b1;
            end
        end
    end

    assign take_o    = take;
    assign idx_o     = cnt_q;
    assign blk_o     = blk_q;
    assign blk_end_o = blk_end;
    assign early_o   = early;
    assign done_o    = done_q;
    assign mis_o     = mis_q;

endmodule

// File: rtl/ecc_accum.sv
module ecc_accum
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic [BYTE_W-1:0] idx_i,
    input  logic [7:0]        data_i,
    output code_t             code_o
);

    code_t acc_q, acc_d;

    always_comb begin
        acc_d = acc_q;
        if (take_i) acc_d = acc_q ^ byte_contrib(idx_i, data_i);
    end

    always_ff @(posedge clk) begin
        if (rst)        acc_q <= '0;
        else if (clr_i) acc_q <= '0;
        else            acc_q <= acc_d;
    end

    assign code_o = acc_d;

endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
    import nand_ecc_pkg::*;
(
    input  code_t    stored_i,
    input  code_t    calc_i,
    output blk_rep_t rep_o
);

    code_t            syn;
    logic [PAIRS-1:0] one_hot_pair;
    logic [PAIRS-1:0] odd_bits;

    assign syn = stored_i ^ calc_i;

    always_comb begin
        for (int p = 0; p < PAIRS; p++) begin
            one_hot_pair[p] = syn[2*p] ^ syn[2*p+1];
            odd_bits[p]     = syn[2*p+1];
        end
        rep_o = '0;
        if (syn == '0) begin
            rep_o.stat = ST_CLEAN;
        end else if (&one_hot_pair) begin
            rep_o.stat     = ST_FIXED;
            rep_o.bit_loc  = odd_bits[BIT_W-1:0];
            rep_o.byte_loc = odd_bits[PAIRS-1:BIT_W];
        end else if ($countones(syn) == 1) begin
            rep_o.stat = ST_CODEERR;
        end else begin
            rep_o.stat = ST_BAD;
        end
    end

endmodule

// File: rtl/nand_block_ecc.sv
module nand_block_ecc
    import nand_ecc_pkg::*;
#(
    parameter int NUM_BLK = 4,
    localparam int IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_start_i,
    input  logic [BYTE_W-1:0] acc_addr_lo_i,
    input  logic              data_valid_i,
    input  logic [7:0]        data_i,
    input  logic              data_last_i,
    input  logic              cmp_valid_i,
    input  logic [IDX_W-1:0]  cmp_idx_i,
    input  logic [CODE_W-1:0] cmp_code_i,
    input  logic              sw_clr_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [CODE_W-1:0] rd_code_o,
    output logic [1:0]        rd_status_o,
    output logic              rd_invalid_o,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic [BIT_W-1:0]  rd_bit_o,
    output logic              done_o,
    output logic              misalign_o
);

    logic              arm;
    logic              take, blk_end, early;
    logic [BYTE_W-1:0] off;
    logic [IDX_W-1:0]  blk;
    code_t             calc_code;
    code_t             slot_code [NUM_BLK];
    blk_rep_t          slot_rep  [NUM_BLK];
    blk_rep_t          cmp_rep;
    code_t             cmp_calc;

    assign arm = acc_start_i && (acc_addr_lo_i == '0);

    ecc_ctrl #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .arm_i     (arm),
        .valid_i   (data_valid_i),
        .last_i    (data_last_i),
        .sw_clr_i  (sw_clr_i),
        .take_o    (take),
        .idx_o     (off),
        .blk_o     (blk),
        .blk_end_o (blk_end),
        .early_o   (early),
        .done_o    (done_o),
        .mis_o     (misalign_o)
    );

    ecc_accum accum_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (arm || blk_end || early),
        .take_i (take),
        .idx_i  (off),
        .data_i (data_i),
        .code_o (calc_code)
    );

    assign cmp_calc = slot_code[cmp_idx_i];

    ecc_syndrome synd_i (
        .stored_i (cmp_code_i),
        .calc_i   (cmp_calc),
        .rep_o    (cmp_rep)
    );

    for (genvar s = 0; s < NUM_BLK; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_code[s] <= '0;
                slot_rep[s]  <= '0;
            end else if (arm) begin
                slot_code[s] <= '0;
                slot_rep[s]  <= '0;
            end else begin
                if (blk_end && (blk == IDX_W'(s)))
                    slot_code[s] <= calc_code;
                if (early && (blk == IDX_W'(s)))
                    slot_rep[s].invalid <= 1'b1;
                if (cmp_valid_i && (cmp_idx_i == IDX_W'(s))) begin
                    slot_rep[s].stat     <= cmp_rep.stat;
                    slot_rep[s].byte_loc <= cmp_rep.byte_loc;
                    slot_rep[s].bit_loc  <= cmp_rep.bit_loc;
                end
            end
        end
    end

    assign rd_code_o    = slot_code[rd_idx_i];
    assign rd_status_o  = slot_rep[rd_idx_i].stat;
    assign rd_invalid_o = slot_rep[rd_idx_i].invalid;
    assign rd_byte_o    = slot_rep[rd_idx_i].byte_loc;
    assign rd_bit_o     = slot_rep[rd_idx_i].bit_loc;

endmodule

// File: rtl/nand_block_ecc_chk.sv
module nand_block_ecc_chk (
    input logic       clk,
    input logic       rst,
    input logic       acc_start_i,
    input logic [8:0] acc_addr_lo_i,
    input logic       data_valid_i,
    input logic       data_last_i,
    input logic       sw_clr_i,
    input logic [1:0] rd_status_o,
    input logic       rd_invalid_o,
    input logic       done_o,
    input logic       misalign_o
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!done_o && !misalign_o && rd_status_o == 2'd0 && !rd_invalid_o)); // R1

    AST_UNALIGNED_NO_ARM: assert property (@(posedge clk) disable iff (rst)
        (acc_start_i && acc_addr_lo_i != 9'd0 && !data_valid_i && !sw_clr_i)
        |=> $stable(done_o)); // R2

    AST_DONE_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(data_valid_i)); // R5

    AST_MISALIGN_FROM_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(misalign_o) |-> $past(data_valid_i && data_last_i)); // R10

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done_o && !sw_clr_i && !(acc_start_i && acc_addr_lo_i == 9'd0))
        |=> done_o); // R11

    AST_MISALIGN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (misalign_o && !sw_clr_i) |=> misalign_o); // R11

endmodule

bind nand_block_ecc nand_block_ecc_chk chk_i (.*);

// File: tb/nand_block_ecc_tb_top.sv
module nand_block_ecc_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_start_i = 1'b0;
    logic [8:0]  acc_addr_lo_i = '0;
    logic        data_valid_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        data_last_i = 1'b0;
    logic        cmp_valid_i = 1'b0;
    logic [1:0]  cmp_idx_i = '0;
    logic [23:0] cmp_code_i = '0;
    logic        sw_clr_i = 1'b0;
    logic [1:0]  rd_idx_i = '0;
    logic [23:0] rd_code_o;
    logic [1:0]  rd_status_o;
    logic        rd_invalid_o;
    logic [8:0]  rd_byte_o;
    logic [2:0]  rd_bit_o;
    logic        done_o;
    logic        misalign_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nand_block_ecc dut_i (.*);

    // pat[23:22] kind[21:20] byte[19:11] bit[10:8] codebit[7:3] spare[2:0]
    // kind: 0 match, 1 one data bit, 2 one code bit, 3 two data bits
    localparam logic [23:0] VEC [9] = '{
        {2'd0, 2'd0, 9'd0,   3'd0, 5'd0,  3'd0},
        {2'd1, 2'd0, 9'd0,   3'd0, 5'd0,  3'd0},
        {2'd2, 2'd1, 9'd0,   3'd0, 5'd0,  3'd0},
        {2'd3, 2'd1, 9'd511, 3'd7, 5'd0,  3'd0},
        {2'd2, 2'd1, 9'd170, 3'd5, 5'd0,  3'd0},
        {2'd3, 2'd2, 9'd0,   3'd0, 5'd23, 3'd0},
        {2'd0, 2'd2, 9'd0,   3'd0, 5'd0,  3'd0},
        {2'd2, 2'd3, 9'd77,  3'd2, 5'd0,  3'd0},
        {2'd1, 2'd3, 9'd300, 3'd6, 5'd0,  3'd0}
    };

    function automatic logic [7:0] gen(int pat, int i, int blk);
        case (pat)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'((i + 17 * blk) ^ (i >> 8));
            default: return 8'(i * 37 + blk * 91 + 11);
        endcase
    endfunction

    // Bit-serial reference: every set data bit toggles one half of every pair.
    function automatic logic [23:0] model(int pat, int blk, int fa, int fab, int fb, int fbb);
        logic [23:0] c = '0;
        for (int i = 0; i < 512; i++) begin
            logic [7:0] d = gen(pat, i, blk);
            if (i == fa) d[fab] = ~d[fab];
            if (i == fb) d[fbb] = ~d[fbb];
            for (int b = 0; b < 8; b++) begin
                if (d[b]) begin
                    for (int k = 0; k < 3; k++) c[2*k + ((b >> k) & 1)] ^= 1'b1;
                    for (int j = 0; j < 9; j++) c[2*(3+j) + ((i >> j) & 1)] ^= 1'b1;
                end
            end
        end
        return c;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_acc(logic [8:0] lo);
        @(negedge clk);
        acc_start_i = 1'b1;
        acc_addr_lo_i = lo;
        @(negedge clk);
        acc_start_i = 1'b0;
    endtask

    // Stream n bytes; global byte g belongs to block g/512, offset g%512.
    task automatic stream(int pat, int n, bit last, int fa, int fab, int fb, int fbb);
        for (int g = 0; g < n; g++) begin
            logic [7:0] d = gen(pat, g % 512, g / 512);
            if (g == fa) d[fab] = ~d[fab];
            if (g == fb) d[fbb] = ~d[fbb];
            @(negedge clk);
            data_valid_i = 1'b1;
            data_i = d;
            data_last_i = last && (g == n - 1);
        end
        @(negedge clk);
        data_valid_i = 1'b0;
        data_last_i = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        sw_clr_i = 1'b1;
        @(negedge clk);
        sw_clr_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] saved;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 done", done_o, 0);
        check("R1 misalign", misalign_o, 0);
        for (int s = 0; s < 4; s++) begin
            rd_idx_i = 2'(s);
            #1;
            check("R1 code", rd_code_o, 0);
            check("R1 status", rd_status_o, 0);
            check("R1 invalid", rd_invalid_o, 0);
        end
        rd_idx_i = 2'd0;

        // Vector walk: R3 code, R5 close, R6..R9 verdicts, R7 location
        for (int v = 0; v < 9; v++) begin
            int pat  = int'(VEC[v][23:22]);
            int kind = int'(VEC[v][21:20]);
            int fby  = int'(VEC[v][19:11]);
            int fbi  = int'(VEC[v][10:8]);
            int cbit = int'(VEC[v][7:3]);
            logic [23:0] good = model(pat, 0, -1, 0, -1, 0);
            logic [23:0] stored;
            int fa = -1, fb = -1;
            start_acc(9'd0);
            stream(pat, 512, 1'b1, -1, 0, -1, 0);
            rd_idx_i = 2'd0;
            #1;
            check("R3 code of block", rd_code_o, good);
            check("R5 done after last", done_o, 1);
            if (kind == 1 || kind == 3) fa = fby;
            if (kind == 3) fb = fby;
            start_acc(9'd0);
            check("R11 aligned start clears done", done_o, 0);
            stream(pat, 512, 1'b1, fa, fbi, fb, fbi ^ 1);
            stored = good;
            if (kind == 2) stored[cbit] = ~stored[cbit];
            @(negedge clk);
            cmp_valid_i = 1'b1;
            cmp_idx_i = 2'd0;
            cmp_code_i = stored;
            @(negedge clk);
            cmp_valid_i = 1'b0;
            case (kind)
                0: check("R6 clean status", rd_status_o, 0);
                1: begin
                    check("R7 corrected status", rd_status_o, 1);
                    check("R7 byte index", rd_byte_o, fby);
                    check("R7 bit index", rd_bit_o, fbi);
                end
                2: check("R8 code error status", rd_status_o, 2);
                default: check("R9 uncorrectable status", rd_status_o, 3);
            endcase
        end

        // R2 unaligned start is ignored
        pulse_clr();
        rd_idx_i = 2'd0;
        #1;
        saved = rd_code_o;
        start_acc(9'h104);
        stream(3, 20, 1'b1, -1, 0, -1, 0);
        check("R2 done stays low", done_o, 0);
        check("R2 code unchanged", rd_code_o, saved);
        check("R2 no misalign", misalign_o, 0);

        // R4 four-block page
        start_acc(9'd0);
        stream(2, 512, 1'b0, -1, 0, -1, 0);
        check("R4 not done mid page", done_o, 0);
        stream(2, 1536, 1'b1, -1, 0, -1, 0);
        check("R5 done at page end", done_o, 1);
        for (int s = 0; s < 4; s++) begin
            rd_idx_i = 2'(s);
            #1;
            // blocks 1..3 were streamed with block seed 0..2 by the second call
            check("R4 slot code", rd_code_o, model(2, (s == 0) ? 0 : s - 1, -1, 0, -1, 0));
        end
        rd_idx_i = 2'd1;
        #1;
        saved = rd_code_o;
        stream(1, 600, 1'b0, -1, 0, -1, 0);
        check("R5 bytes after close ignored", rd_code_o, saved);

        // R11 software clear
        pulse_clr();
        check("R11 clear drops done", done_o, 0);

        // R10 early last
        start_acc(9'd0);
        stream(3, 100, 1'b1, -1, 0, -1, 0);
        rd_idx_i = 2'd0;
        #1;
        check("R10 misalign set", misalign_o, 1);
        check("R10 slot invalid", rd_invalid_o, 1);
        check("R10 done raised", done_o, 1);
        start_acc(9'd0);
        check("R11 misalign kept across start", misalign_o, 1);
        check("R11 invalid cleared by start", rd_invalid_o, 0);
        pulse_clr();
        check("R11 clear drops misalign", misalign_o, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule